// File: doc/BRIEF.md
# SPI Command Frame Decoder

This block is the serial front end of a small register-mapped control device. A host talks to it over a four-wire serial link in mode 0: the block samples the data line on rising serial-clock edges, changes its own data output on falling edges, and treats the most significant bit of every byte as the first one on the wire. The serial clock, data line and select line all come from off chip. A faster system clock samples them through short synchroniser chains. All decoding and all outputs work in the system-clock domain.

Each transaction starts when the select line falls and carries exactly three bytes. The first byte identifies the device. The second holds an opcode in its upper nibble and a register pointer in its two lowest bits. The third is either the data to write or a dummy byte during which the block shifts a register value back out. A read raises a one-cycle request with the pointer, takes the register value from the attached storage on the next cycle, and returns it during the third byte. A write is only staged while the bytes arrive. It is issued as a one-cycle strobe with pointer and data after the select line returns high. A frame that fails any check, or has the wrong number of bits, produces no request and no strobe.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After reset, `sdo_en_o`, `sdo_o`, `wr_stb_o` and `rd_req_o` are all low.
- R2: Serial data is taken on rising serial-clock edges, most significant bit first, so the data byte appears on `wr_data_o` unreversed (0x01 and 0x80 stay distinct).
- R3: The first byte of a frame must equal 0x50. Any other value suppresses every request and strobe for that frame.
- R4: The opcode sits in bits 7:4 of the second byte. 4'b1011 is a read and 4'b1100 is a write. Any other opcode makes the frame inert.
- R5: The pointer sits in bits 1:0 of the second byte. Only 2'b00 and 2'b10 are accepted. 2'b01 and 2'b11 make the frame inert. A strobe or request always carries an accepted pointer.
- R6: For a valid read, `rd_req_o` pulses for one cycle, with the pointer on `rd_addr_o`, once the sixteenth bit has been sampled. The value on `rd_data_i` in the following cycle is shifted out on `sdo_o` on falling serial-clock edges, MSB first, so that each bit is stable before the rising edge of its position in the third byte. Outside a valid read the line carries 0.
- R7: A valid write pulses `wr_stb_o` for one cycle, with pointer and data, only after the select line goes high, and only if exactly 24 bits were clocked in.
- R8: A frame that ends with fewer than 24 bits, or with more than 24, produces no write strobe.
- R9: `sdo_en_o` is high only while the device is selected within a frame, and returns low within a few cycles of the select line going high.
- R10: A frame counts only after a falling edge of the select line. If the select line is already low when reset ends, clock edges before the next falling edge are ignored.
- R11: `wr_stb_o` and `rd_req_o` are never high in the same cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| csn_i | input | 1 | Active-low device select from the host |
| sdo_o | output | 1 | Serial data towards the host |
| sdo_en_o | output | 1 | Output enable for `sdo_o`; low means the pad is high impedance |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 2 | Register pointer of the write |
| wr_data_o | output | 8 | Data byte of the write |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | 2 | Register pointer of the read |
| rd_data_i | input | 8 | Register value, sampled the cycle after `rd_req_o` |

## Verification
A bit counter that slips by one position shows up at once at the ports. The captured data byte comes out shifted, a good frame is rejected as short or overlong, or the read request fires a bit early. Each of these is visible as soon as the select line rises or as the first returned bit. A validity flag that sticks or fails to clear shows up as a missing or extra strobe in the first frame after the bad one. This is why the tests send inert frames directly between good ones. A broken output shifter is caught at the first read, because the returned patterns mix ones and zeros in both halves of the byte.

// File: rtl/spi_fd_pkg.sv
package spi_fd_pkg;

  localparam int OPC_W = 4;
  localparam int PTR_W = 2;

  localparam logic [OPC_W-1:0] OPC_READ  = 4'b1011;
  localparam logic [OPC_W-1:0] OPC_WRITE = 4'b1100;

  localparam logic [PTR_W-1:0] PTR_WIPER = 2'b00;
  localparam logic [PTR_W-1:0] PTR_CTRL  = 2'b10;

  typedef enum logic [1:0] {
    OPK_NONE  = 2'd0,
    OPK_READ  = 2'd1,
    OPK_WRITE = 2'd2
  } op_kind_e;

endpackage

// File: rtl/spi_fd_sync.sv
module spi_fd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic csn_i,
  output logic sdi_o,
  output logic cs_low_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o
);

  localparam int EDGE_LEN = STAGES + 1;

  logic [1:0] edge_raw;
  logic [1:0] cur;
  logic [1:0] prv;
  logic [STAGES-1:0] sdi_chain;

  assign edge_raw = {csn_i, sck_i};

  // Edge-detected lines get one flop beyond the synchroniser for comparison.
  // All chains reset to 0 so a select held low through reset shows no fall.
  for (genvar g = 0; g < 2; g++) begin : g_edge
    logic [EDGE_LEN-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[EDGE_LEN-2:0], edge_raw[g]};
    end
    assign cur[g] = chain[STAGES-1];
    assign prv[g] = chain[STAGES];
  end

  always_ff @(posedge clk) begin
    if (rst) sdi_chain <= '0;
    else     sdi_chain <= {sdi_chain[STAGES-2:0], sdi_i};
  end

  assign sdi_o      = sdi_chain[STAGES-1];
  assign cs_low_o   = ~cur[1];
  assign sck_rise_o = cur[0] & ~prv[0];
  assign sck_fall_o = ~cur[0] & prv[0];
  assign cs_fall_o  = ~cur[1] & prv[1];
  assign cs_rise_o  = cur[1] & ~prv[1];

endmodule

// File: rtl/spi_fd_decode.sv
module spi_fd_decode
  import spi_fd_pkg::*;
#(
  parameter int                 DATA_W   = 8,
  parameter logic [DATA_W-1:0]  ID_VALUE = 8'h50
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic              id_ok_o,
  output logic              ins_ok_o,
  output op_kind_e          op_o,
  output logic [PTR_W-1:0]  ptr_o
);

  logic [OPC_W-1:0] opc;
  logic             ptr_ok;

  assign opc   = byte_i[DATA_W-1 -: OPC_W];
  assign ptr_o = byte_i[PTR_W-1:0];

  always_comb begin
    case (opc)
      OPC_READ:  op_o = OPK_READ;
      OPC_WRITE: op_o = OPK_WRITE;
      default:   op_o = OPK_NONE;
    endcase
  end

  assign ptr_ok   = (ptr_o == PTR_WIPER) || (ptr_o == PTR_CTRL);
  assign ins_ok_o = (op_o != OPK_NONE) && ptr_ok;
  assign id_ok_o  = (byte_i == ID_VALUE);

endmodule

// File: rtl/spi_fd_rx.sv
module spi_fd_rx
  import spi_fd_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                FRAME_BYTES = 3,
  parameter logic [DATA_W-1:0] ID_VALUE    = 8'h50,
  parameter int                CNT_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi_i,
  input  logic              sck_rise_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  output logic              rd_req_o,
  output logic [PTR_W-1:0]  rd_addr_o,
  output logic              wr_stb_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              read_ok_o,
  output logic              armed_o
);

  localparam int FRAME_BITS = DATA_W * FRAME_BYTES;
  localparam logic [CNT_W-1:0] ID_LAST  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] INS_LAST = CNT_W'(2 * DATA_W - 1);
  localparam logic [CNT_W-1:0] INS_DONE = CNT_W'(2 * DATA_W);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] OVER     = CNT_W'(FRAME_BITS + 1);

  logic [DATA_W-2:0] rx;
  logic [DATA_W-1:0] rx_next;
  logic [DATA_W-1:0] wdata;
  logic [CNT_W-1:0]  cnt;
  logic              armed;
  logic              bad;
  op_kind_e          op;
  logic [PTR_W-1:0]  ptr;

  logic              id_ok;
  logic              ins_ok;
  op_kind_e          dec_op;
  logic [PTR_W-1:0]  dec_ptr;

  assign rx_next = {rx, sdi_i};

  spi_fd_decode #(
    .DATA_W   (DATA_W),
    .ID_VALUE (ID_VALUE)
  ) u_decode (
    .byte_i   (rx_next),
    .id_ok_o  (id_ok),
    .ins_ok_o (ins_ok),
    .op_o     (dec_op),
    .ptr_o    (dec_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx        <= '0;
      wdata     <= '0;
      cnt       <= '0;
      armed     <= 1'b0;
      bad       <= 1'b0;
      op        <= OPK_NONE;
      ptr       <= '0;
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      rd_req_o <= 1'b0;
      wr_stb_o <= 1'b0;
      if (cs_fall_i) begin
        armed <= 1'b1;
        cnt   <= '0;
        bad   <= 1'b0;
        op    <= OPK_NONE;
      end else if (cs_rise_i) begin
        // Commit only a clean write frame of exactly the full length.
        if (armed && cnt == FULL && !bad && op == OPK_WRITE) begin
          wr_stb_o  <= 1'b1;
          wr_addr_o <= ptr;
          wr_data_o <= wdata;
        end
        armed <= 1'b0;
      end else if (sck_rise_i && armed) begin
        rx <= rx_next[DATA_W-2:0];
        if (cnt != OVER) cnt <= cnt + 1'b1;
        if (cnt == ID_LAST && !id_ok) bad <= 1'b1;
        if (cnt == INS_LAST) begin
          if (!ins_ok) begin
            bad <= 1'b1;
          end else begin
            op  <= dec_op;
            ptr <= dec_ptr;
            if (dec_op == OPK_READ && !bad) begin
              rd_req_o  <= 1'b1;
              rd_addr_o <= dec_ptr;
            end
          end
        end
        if (cnt == DAT_LAST) wdata <= rx_next;
      end
    end
  end

  assign bit_cnt_o = cnt;
  assign armed_o   = armed;
  assign read_ok_o = armed && !bad && (op == OPK_READ);

  p_wr_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o);

  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |=> !rd_req_o);

  p_rd_after_instr_r6: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> (cnt == INS_DONE) && armed);

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= OVER);

  p_wr_ptr_legal_r5: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> (wr_addr_o == PTR_WIPER || wr_addr_o == PTR_CTRL));

endmodule

// File: rtl/spi_fd_tx.sv
module spi_fd_tx #(
  parameter int DATA_W      = 8,
  parameter int FRAME_BYTES = 3,
  parameter int CNT_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_fall_i,
  input  logic              cs_low_i,
  input  logic              armed_i,
  input  logic              read_ok_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sdo_o,
  output logic              sdo_en_o
);

  localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(DATA_W * (FRAME_BYTES - 1));
  localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(DATA_W * FRAME_BYTES);

  logic [DATA_W-1:0] tx;
  logic              load_q;
  logic              in_window;

  assign in_window = (bit_cnt_i >= WIN_LO) && (bit_cnt_i < WIN_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx       <= '0;
      load_q   <= 1'b0;
      sdo_o    <= 1'b0;
      sdo_en_o <= 1'b0;
    end else begin
      load_q   <= load_i;
      sdo_en_o <= armed_i & cs_low_i;
      if (load_q) begin
        tx <= rd_data_i;
      end else if (sck_fall_i && cs_low_i && read_ok_i && in_window) begin
        tx <= {tx[DATA_W-2:0], 1'b0};
      end
      if (!cs_low_i) begin
        sdo_o <= 1'b0;
      end else if (sck_fall_i) begin
        sdo_o <= (read_ok_i && in_window) ? tx[DATA_W-1] : 1'b0;
      end
    end
  end

  p_sdo_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !read_ok_i |=> !sdo_o);

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_fd_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                FRAME_BYTES = 3,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_VALUE    = 8'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              csn_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic              wr_stb_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic [PTR_W-1:0]  rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);

  localparam int FRAME_BITS = DATA_W * FRAME_BYTES;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  logic             sdi_s;
  logic             cs_low;
  logic             sck_rise;
  logic             sck_fall;
  logic             cs_fall;
  logic             cs_rise;
  logic [CNT_W-1:0] bit_cnt;
  logic             read_ok;
  logic             armed;

  spi_fd_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .rst        (rst),
    .sck_i      (sck_i),
    .sdi_i      (sdi_i),
    .csn_i      (csn_i),
    .sdi_o      (sdi_s),
    .cs_low_o   (cs_low),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .cs_fall_o  (cs_fall),
    .cs_rise_o  (cs_rise)
  );

  spi_fd_rx #(
    .DATA_W      (DATA_W),
    .FRAME_BYTES (FRAME_BYTES),
    .ID_VALUE    (ID_VALUE),
    .CNT_W       (CNT_W)
  ) u_rx (
    .clk        (clk),
    .rst        (rst),
    .sdi_i      (sdi_s),
    .sck_rise_i (sck_rise),
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .wr_stb_o   (wr_stb_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .bit_cnt_o  (bit_cnt),
    .read_ok_o  (read_ok),
    .armed_o    (armed)
  );

  spi_fd_tx #(
    .DATA_W      (DATA_W),
    .FRAME_BYTES (FRAME_BYTES),
    .CNT_W       (CNT_W)
  ) u_tx (
    .clk        (clk),
    .rst        (rst),
    .sck_fall_i (sck_fall),
    .cs_low_i   (cs_low),
    .armed_i    (armed),
    .read_ok_i  (read_ok),
    .bit_cnt_i  (bit_cnt),
    .load_i     (rd_req_o),
    .rd_data_i  (rd_data_i),
    .sdo_o      (sdo_o),
    .sdo_en_o   (sdo_en_o)
  );

  p_one_kind_r11: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb_o && rd_req_o));

  p_wr_deselected_r7: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> !sdo_en_o);

endmodule

// File: tb/spi_cmd_frontend_tb.sv
module spi_cmd_frontend_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0;
  logic       sdi = 1'b0;
  logic       csn = 1'b1;
  logic       sdo;
  logic       sdo_en;
  logic       wr_stb;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       rd_req;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic [7:0] reg_wiper = 8'h3C;
  logic [7:0] reg_ctrl  = 8'hA5;

  int checks = 0;
  int errors = 0;
  int wr_seen = 0;
  int rd_seen = 0;
  int both_seen = 0;
  logic [1:0] last_waddr;
  logic [7:0] last_wdata;
  logic [1:0] last_raddr;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign rd_data = (rd_addr == 2'b10) ? reg_ctrl : reg_wiper;

  spi_cmd_frontend u_dut (
    .clk       (clk),
    .rst       (rst),
    .sck_i     (sck),
    .sdi_i     (sdi),
    .csn_i     (csn),
    .sdo_o     (sdo),
    .sdo_en_o  (sdo_en),
    .wr_stb_o  (wr_stb),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .rd_req_o  (rd_req),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb) begin wr_seen++; last_waddr = wr_addr; last_wdata = wr_data; end
      if (rd_req) begin rd_seen++; last_raddr = rd_addr; end
      if (wr_stb && rd_req) both_seen++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic cs_level);
    csn = cs_level; sck = 1'b0; sdi = 1'b0;
    @(negedge clk) rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic spi_frame(input logic [23:0] frame, input int nbits, input bit do_cs,
                           output logic [7:0] got, output logic en_mid);
    got = '0; en_mid = 1'b0;
    if (do_cs) begin @(negedge clk) csn = 1'b0; end
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 24) ? frame[23-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i == 4) en_mid = sdo_en;
      if (i >= 16 && i < 24) got[23-i] = sdo;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset_r1();
    do_reset(1'b1);
    chk(sdo_en == 1'b0, "R1 sdo_en after reset", sdo_en, 0);
    chk(sdo == 1'b0, "R1 sdo after reset", sdo, 0);
    chk(wr_seen == 0 && rd_seen == 0, "R1 no pulses after reset", wr_seen + rd_seen, 0);
  endtask

  task automatic t_write_r2_r7();
    logic [7:0] g; logic en; int w0;
    w0 = wr_seen;
    spi_frame(24'h50C077, 24, 1'b1, g, en);
    chk(wr_seen == w0 + 1, "R7 write strobe count", wr_seen - w0, 1);
    chk(last_waddr == 2'b00 && last_wdata == 8'h77, "R7 write addr/data",
        {last_waddr, last_wdata}, {2'b00, 8'h77});
    chk(en == 1'b1, "R9 sdo_en within frame", en, 1);
    chk(sdo_en == 1'b0, "R9 sdo_en after deselect", sdo_en, 0);
    spi_frame(24'h50C201, 24, 1'b1, g, en);
    chk(last_waddr == 2'b10 && last_wdata == 8'h01, "R2 msb-first 01",
        {last_waddr, last_wdata}, {2'b10, 8'h01});
    spi_frame(24'h50C080, 24, 1'b1, g, en);
    chk(last_wdata == 8'h80, "R2 msb-first 80", last_wdata, 8'h80);
    chk(both_seen == 0, "R11 no overlap of strobe and request", both_seen, 0);
  endtask

  task automatic t_read_r6();
    logic [7:0] g; logic en; int r0, w0;
    r0 = rd_seen; w0 = wr_seen;
    reg_wiper = 8'h3C; reg_ctrl = 8'hA5;
    spi_frame(24'h50B000, 24, 1'b1, g, en);
    chk(rd_seen == r0 + 1 && last_raddr == 2'b00, "R6 read request wiper",
        rd_seen - r0, 1);
    chk(g == 8'h3C, "R6 read data wiper", g, 8'h3C);
    spi_frame(24'h50B2FF, 24, 1'b1, g, en);
    chk(last_raddr == 2'b10 && g == 8'hA5, "R6 read data ctrl", g, 8'hA5);
    reg_ctrl = 8'h5A;
    spi_frame(24'h50B200, 24, 1'b1, g, en);
    chk(g == 8'h5A, "R6 read data pattern 5A", g, 8'h5A);
    chk(wr_seen == w0, "R11 read issues no write", wr_seen - w0, 0);
  endtask

  task automatic t_bad_id_r3();
    logic [7:0] g; logic en; int w0, r0;
    w0 = wr_seen; r0 = rd_seen;
    spi_frame(24'h51C012, 24, 1'b1, g, en);
    spi_frame(24'hD0B000, 24, 1'b1, g, en);
    chk(wr_seen == w0 && rd_seen == r0, "R3 wrong id inert",
        wr_seen - w0 + rd_seen - r0, 0);
    chk(g == 8'h00, "R3 wrong id no read data", g, 0);
  endtask

  task automatic t_bad_op_r4();
    logic [7:0] g; logic en; int w0, r0;
    w0 = wr_seen; r0 = rd_seen;
    spi_frame(24'h50D012, 24, 1'b1, g, en);
    spi_frame(24'h50A000, 24, 1'b1, g, en);
    chk(wr_seen == w0 && rd_seen == r0, "R4 illegal opcode inert",
        wr_seen - w0 + rd_seen - r0, 0);
    chk(g == 8'h00, "R4 illegal opcode sdo quiet", g, 0);
  endtask

  task automatic t_bad_ptr_r5();
    logic [7:0] g; logic en; int w0, r0;
    w0 = wr_seen; r0 = rd_seen;
    spi_frame(24'h50C112, 24, 1'b1, g, en);
    spi_frame(24'h50B300, 24, 1'b1, g, en);
    chk(wr_seen == w0 && rd_seen == r0, "R5 unused pointer inert",
        wr_seen - w0 + rd_seen - r0, 0);
    chk(g == 8'h00, "R5 unused pointer sdo quiet", g, 0);
    spi_frame(24'h50C2C3, 24, 1'b1, g, en);
    chk(wr_seen == w0 + 1 && last_wdata == 8'hC3, "R5 good frame after bad ones",
        last_wdata, 8'hC3);
  endtask

  task automatic t_length_r8();
    logic [7:0] g; logic en; int w0;
    w0 = wr_seen;
    spi_frame(24'h50C055, 20, 1'b1, g, en);
    chk(wr_seen == w0, "R8 short frame dropped", wr_seen - w0, 0);
    spi_frame(24'h50C055, 25, 1'b1, g, en);
    chk(wr_seen == w0, "R8 long frame dropped", wr_seen - w0, 0);
  endtask

  task automatic t_no_fall_r10();
    logic [7:0] g; logic en; int w0;
    do_reset(1'b0);
    w0 = wr_seen;
    spi_frame(24'h50C066, 24, 1'b0, g, en);
    chk(wr_seen == w0, "R10 no frame without select fall", wr_seen - w0, 0);
    chk(en == 1'b0, "R10 sdo_en stays low without frame", en, 0);
    spi_frame(24'h50C099, 24, 1'b1, g, en);
    chk(wr_seen == w0 + 1 && last_wdata == 8'h99, "R10 next framed write works",
        last_wdata, 8'h99);
  endtask

  initial begin
    t_reset_r1();
    t_write_r2_r7();
    t_read_r6();
    t_bad_id_r3();
    t_bad_op_r4();
    t_bad_ptr_r5();
    t_length_r8();
    t_no_fall_r10();
    chk(both_seen == 0, "R11 final overlap count", both_seen, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule